// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block executes a single atomic memory instruction from a compact virtual instruction set. On a start strobe it captures an 8-bit opcode, a 32-bit operation selector, a base address, a signed 16-bit displacement, the source operand and the R0 operand. It then runs one locked read and an optional write on a synchronous memory port that uses a request/ready handshake. When it finishes it pulses done and reports any register write-backs. These are the old memory value for the source register, the old memory value for R0, or neither.

The selector picks one of four plain updates (add, or, and, xor), an exchange, or a compare-and-exchange. Bit 0 of the selector is a fetch modifier that returns the old memory value. The lock output stays high for the whole read-modify-write window, so an external arbiter can keep other masters away from memory. A malformed opcode or selector is refused: the block makes no memory access, requests no register update and reports only the illegal flag.

Top module: `atom_rmw_unit`

## Requirements
- R1: An opcode is legal only if bits [7:5]=6, bits [2:0]=3 and bits [4:3] are 0 (32-bit, opcode 0xC3) or 3 (64-bit, opcode 0xDB). Any other opcode, including the 8-bit and 16-bit sizes (0xD3, 0xCB), raises illegal_o with done_o.
- R2: Selector 0x00 adds, 0x40 ORs, 0x50 ANDs and 0xA0 XORs the source operand into the memory word, and the result is written back to the same address.
- R3: When selector bit 0 is set on a plain update, src_wb_o is asserted with done_o and src_wb_data_o holds the memory value from before the update. With bit 0 clear, src_wb_o stays low.
- R4: Selector 0xE1 writes the source operand to memory and returns the old memory value through src_wb_data_o.
- R5: Selector 0xF1 writes the source operand only when the old memory value equals the R0 operand. Otherwise no write request is issued and memory is unchanged.
- R6: For selector 0xF1, r0_wb_o is asserted with done_o and r0_wb_data_o carries the old memory value zero-extended to 64 bits, whether or not the compare matched. src_wb_o stays low.
- R7: The memory address is the base plus the sign-extended 16-bit displacement.
- R8: In 32-bit form (mem_size64_o=0), only the low 32 bits of the operands, the compare and the result take part, arithmetic wraps at 32 bits, and every register write-back value has its upper 32 bits zero.
- R9: Any selector value not listed in R2 to R6 (including nonzero bits above bit 7) raises illegal_o, issues no memory request and asserts no write-back.
- R10: mem_lock_o is high whenever mem_req_o is high and stays high from the read request until the write is accepted. A request holds its address and direction until mem_ready_i.
- R11: done_o is a one-cycle pulse. A start strobe that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| opcode_i | input | 8 | Instruction opcode |
| sel_i | input | 32 | Operation selector (immediate) |
| base_i | input | 32 | Base address |
| disp_i | input | 16 | Signed displacement |
| src_i | input | 64 | Source operand |
| r0_i | input | 64 | R0 operand (compare value) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_size64_o | output | 1 | 1: 64-bit access, 0: 32-bit access in low half |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Memory accepts the current request |
| mem_rdata_i | input | 64 | Read data, valid with mem_ready_i on a read |
| mem_lock_o | output | 1 | Bus lock held over the read-modify-write |
| done_o | output | 1 | Operation complete (one-cycle pulse) |
| illegal_o | output | 1 | Operation refused, valid with done_o |
| src_wb_o | output | 1 | Source register write-back request |
| src_wb_data_o | output | 64 | Source register write-back value |
| r0_wb_o | output | 1 | R0 write-back request |
| r0_wb_data_o | output | 64 | R0 write-back value |

## Verification
A fresh start strobe can arrive in the same cycle as an operation that still holds the lock and waits on a stalled read or write. The bench provokes this by holding back mem_ready_i for several cycles and pulsing start with a different selector during the stall. It then judges by seeing exactly one done pulse and a memory word that reflects only the first operation. The compare decision and the R0 reload also depend on the same read beat, so matched and mismatched compares in both widths are checked for memory contents and write-back together.

// File: rtl/atom_pkg.sv
package atom_pkg;

   localparam logic [2:0] MODE_ATOMIC = 3'd6;
   localparam logic [2:0] CLASS_STORE_REG = 3'd3;
   localparam logic [1:0] SIZE_WORD = 2'd0;
   localparam logic [1:0] SIZE_DWORD = 2'd3;

   localparam logic [7:0] SEL_ADD = 8'h00;
   localparam logic [7:0] SEL_OR = 8'h40;
   localparam logic [7:0] SEL_AND = 8'h50;
   localparam logic [7:0] SEL_XOR = 8'hA0;
   localparam logic [7:0] SEL_SWAP = 8'hE1;
   localparam logic [7:0] SEL_CAS = 8'hF1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_MODIFY,
      ST_WRITE,
      ST_DONE
   } rmw_state_e;

   typedef enum logic [2:0] {
      OP_ADD,
      OP_OR,
      OP_AND,
      OP_XOR,
      OP_SWAP,
      OP_CAS
   } rmw_op_e;

   typedef struct packed {
      logic    legal;
      logic    wide;
      logic    fetch;
      rmw_op_e op;
   } rmw_dec_t;

endpackage

// File: rtl/atom_decode.sv
module atom_decode
   import atom_pkg::*;
#(
   parameter int OPC_W = 8,
   parameter int SEL_W = 32
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [SEL_W-1:0] sel_i,
   output rmw_dec_t         dec_o
);

   logic       opc_ok;
   logic       sel_ok;
   logic       hi_zero;
   logic [7:0] code;

   assign code    = sel_i[7:0];
   assign hi_zero = (sel_i[SEL_W-1:8] == '0);
   assign opc_ok  = (opcode_i[7:5] == MODE_ATOMIC) &&
                    (opcode_i[2:0] == CLASS_STORE_REG) &&
                    ((opcode_i[4:3] == SIZE_WORD) || (opcode_i[4:3] == SIZE_DWORD));

   always_comb begin
      dec_o       = '0;
      sel_ok      = 1'b1;
      dec_o.wide  = (opcode_i[4:3] == SIZE_DWORD);
      dec_o.fetch = code[0];
      case (code)
         SEL_ADD, SEL_ADD | 8'h01: dec_o.op = OP_ADD;
         SEL_OR,  SEL_OR  | 8'h01: dec_o.op = OP_OR;
         SEL_AND, SEL_AND | 8'h01: dec_o.op = OP_AND;
         SEL_XOR, SEL_XOR | 8'h01: dec_o.op = OP_XOR;
         SEL_SWAP:                 dec_o.op = OP_SWAP;
         SEL_CAS:                  dec_o.op = OP_CAS;
         default: begin
            dec_o.op = OP_ADD;
            sel_ok   = 1'b0;
         end
      endcase
      dec_o.legal = opc_ok && sel_ok && hi_zero;
   end

endmodule

// File: rtl/atom_alu.sv
module atom_alu
   import atom_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  rmw_op_e           op_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] cmp_i,
   output logic [DATA_W-1:0] new_o,
   output logic              write_o
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] a_v;
   logic [DATA_W-1:0] b_v;
   logic [DATA_W-1:0] c_v;
   logic [DATA_W-1:0] res;

   assign mask = wide_i ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
   assign a_v  = old_i & mask;
   assign b_v  = src_i & mask;
   assign c_v  = cmp_i & mask;

   always_comb begin
      write_o = 1'b1;
      case (op_i)
         OP_ADD:  res = a_v + b_v;
         OP_OR:   res = a_v | b_v;
         OP_AND:  res = a_v & b_v;
         OP_XOR:  res = a_v ^ b_v;
         OP_SWAP: res = b_v;
         OP_CAS: begin
            res     = b_v;
            write_o = (a_v == c_v);
         end
         default: begin
            res     = a_v;
            write_o = 1'b0;
         end
      endcase
   end

   assign new_o = res & mask;

endmodule

// File: rtl/atom_rmw_unit.sv
module atom_rmw_unit
   import atom_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int SEL_W  = 32,
   parameter int OPC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] r0_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_size64_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ready_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_lock_o,
   output logic              done_o,
   output logic              illegal_o,
   output logic              src_wb_o,
   output logic [DATA_W-1:0] src_wb_data_o,
   output logic              r0_wb_o,
   output logic [DATA_W-1:0] r0_wb_data_o
);

   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("atom_rmw_unit: DATA_W must be even and at least 16");
      end
      if (SEL_W <= 8) begin : g_bad_sel
         $error("atom_rmw_unit: SEL_W must exceed 8");
      end
      if (OPC_W != 8) begin : g_bad_opc
         $error("atom_rmw_unit: OPC_W must be 8");
      end
   endgenerate

   rmw_state_e        state_q;
   rmw_dec_t          dec_now;
   rmw_dec_t          dec_q;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] src_q;
   logic [DATA_W-1:0] r0_q;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] new_q;
   logic [DATA_W-1:0] alu_new;
   logic              alu_write;

   atom_decode #(.OPC_W(OPC_W), .SEL_W(SEL_W)) u_decode (
      .opcode_i (opcode_i),
      .sel_i    (sel_i),
      .dec_o    (dec_now)
   );

   atom_alu #(.DATA_W(DATA_W)) u_alu (
      .op_i    (dec_q.op),
      .wide_i  (dec_q.wide),
      .old_i   (old_q),
      .src_i   (src_q),
      .cmp_i   (r0_q),
      .new_o   (alu_new),
      .write_o (alu_write)
   );

   generate
      if (ADDR_W > DISP_W) begin : g_disp_sext
         assign eff_addr = base_i + {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_disp_trunc
         assign eff_addr = base_i + disp_i[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dec_q   <= '0;
         addr_q  <= '0;
         src_q   <= '0;
         r0_q    <= '0;
         old_q   <= '0;
         new_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  dec_q   <= dec_now;
                  addr_q  <= eff_addr;
                  src_q   <= src_i;
                  r0_q    <= r0_i;
                  state_q <= dec_now.legal ? ST_READ : ST_DONE;
               end
            end
            ST_READ: begin
               if (mem_ready_i) begin
                  old_q   <= dec_q.wide ? mem_rdata_i
                                        : {{HALF_W{1'b0}}, mem_rdata_i[HALF_W-1:0]};
                  state_q <= ST_MODIFY;
               end
            end
            ST_MODIFY: begin
               new_q   <= alu_new;
               state_q <= alu_write ? ST_WRITE : ST_DONE;
            end
            ST_WRITE: begin
               if (mem_ready_i) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o     = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we_o      = (state_q == ST_WRITE);
   assign mem_lock_o    = mem_req_o || (state_q == ST_MODIFY);
   assign mem_size64_o  = dec_q.wide;
   assign mem_addr_o    = addr_q;
   assign mem_wdata_o   = new_q;
   assign done_o        = (state_q == ST_DONE);
   assign illegal_o     = done_o && !dec_q.legal;
   assign src_wb_o      = done_o && dec_q.legal && dec_q.fetch && (dec_q.op != OP_CAS);
   assign r0_wb_o       = done_o && dec_q.legal && (dec_q.op == OP_CAS);
   assign src_wb_data_o = old_q;
   assign r0_wb_data_o  = old_q;

   assert_req_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> mem_lock_o);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   assert_write_locked_before_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> $past(mem_lock_o));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && illegal_o) |-> (!src_wb_o && !r0_wb_o));

   assert_no_access_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> dec_q.legal);

   assert_narrow_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !dec_q.wide && (src_wb_o || r0_wb_o)) |-> (src_wb_data_o[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/sim_atom_rmw_unit.sv
`timescale 1ns/1ps
module sim_atom_rmw_unit;

   typedef struct packed {
      logic [7:0]  opc;
      logic [31:0] sel;
      logic [15:0] disp;
      logic [63:0] src;
      logic [63:0] r0;
      logic [63:0] init;
      logic [63:0] expw;
      logic        swb;
      logic [63:0] sval;
      logic        rwb;
      logic [63:0] rval;
      logic        ill;
   } vec_t;

   localparam int NVEC = 18;
   localparam logic [31:0] BASE = 32'h40;

   localparam vec_t VEC [NVEC] = '{
      '{8'hDB, 32'h00, 16'h0000, 64'h1, 64'h0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      '{8'hDB, 32'h41, 16'h0008, 64'h0F0F, 64'h0, 64'h00F0, 64'h0FFF, 1'b1, 64'h00F0, 1'b0, 64'h0, 1'b0},
      '{8'hDB, 32'h50, 16'h0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 64'hFF00_FF00_FF00_FF00, 64'h0F00_0F00_0F00_0F00, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      '{8'hDB, 32'hA1, 16'h0000, 64'hFFFF, 64'h0, 64'hAAAA, 64'h5555, 1'b1, 64'hAAAA, 1'b0, 64'h0, 1'b0},
      '{8'hDB, 32'hE1, 16'hFFF8, 64'h1111, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h1111, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, 64'h0, 1'b0},
      '{8'hDB, 32'hF1, 16'h0000, 64'h99, 64'h77, 64'h77, 64'h99, 1'b0, 64'h0, 1'b1, 64'h77, 1'b0},
      '{8'hDB, 32'hF1, 16'h0000, 64'h99, 64'h78, 64'h77, 64'h77, 1'b0, 64'h0, 1'b1, 64'h77, 1'b0},
      '{8'hC3, 32'h01, 16'h0000, 64'hAAAA_AAAA_0000_0002, 64'h0, 64'hDEAD_BEEF_FFFF_FFFF, 64'hDEAD_BEEF_0000_0001, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b0, 64'h0, 1'b0},
      '{8'hC3, 32'hE1, 16'h0004, 64'h1234_5678_CAFE_F00D, 64'h0, 64'h8000_0001_5555_5555, 64'hCAFE_F00D_5555_5555, 1'b1, 64'h0000_0000_8000_0001, 1'b0, 64'h0, 1'b0},
      '{8'hC3, 32'hF1, 16'h0000, 64'h1, 64'hFFFF_FFFF_8765_4321, 64'h0000_0009_8765_4321, 64'h0000_0009_0000_0001, 1'b0, 64'h0, 1'b1, 64'h0000_0000_8765_4321, 1'b0},
      '{8'hC3, 32'hF1, 16'h0000, 64'h5, 64'h0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, 64'h0, 1'b1, 64'h0000_0000_8000_0000, 1'b0},
      '{8'hCB, 32'h00, 16'h0000, 64'h1, 64'h0, 64'h42, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      '{8'hD3, 32'h00, 16'h0000, 64'h1, 64'h0, 64'h42, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      '{8'hDB, 32'h02, 16'h0000, 64'h1, 64'h0, 64'h42, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      '{8'hDB, 32'h100, 16'h0000, 64'h1, 64'h0, 64'h42, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      '{8'hDB, 32'hE0, 16'h0000, 64'h1, 64'h0, 64'h42, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      '{8'hDA, 32'h00, 16'h0000, 64'h1, 64'h0, 64'h42, 64'h42, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      '{8'hC3, 32'h50, 16'h0000, 64'h0000_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_FFFF, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0;
   logic [31:0] sel = '0;
   logic [31:0] base = BASE;
   logic [15:0] disp = '0;
   logic [63:0] src = '0;
   logic [63:0] r0 = '0;
   logic        mem_req, mem_we, mem_size64, mem_ready, mem_lock;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata, mem_rdata;
   logic        done, illegal, src_wb, r0_wb;
   logic [63:0] src_wb_data, r0_wb_data;

   logic [63:0] mem [16];
   int          ready_delay = 0;
   int          wait_cnt = 0;
   int          accepts = 0;
   int          done_seen = 0;
   int          lock_err = 0;
   logic        in_rmw = 1'b0;
   int          checks = 0;
   int          fails = 0;
   int          cycles = 0;

   always #2.5 clk = ~clk;

   atom_rmw_unit u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opcode), .sel_i(sel),
      .base_i(base), .disp_i(disp), .src_i(src), .r0_i(r0),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size64_o(mem_size64),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
      .mem_rdata_i(mem_rdata), .mem_lock_o(mem_lock), .done_o(done),
      .illegal_o(illegal), .src_wb_o(src_wb), .src_wb_data_o(src_wb_data),
      .r0_wb_o(r0_wb), .r0_wb_data_o(r0_wb_data)
   );

   assign mem_ready = mem_req && (wait_cnt >= ready_delay);
   assign mem_rdata = mem_size64 ? mem[mem_addr[6:3]]
                    : (mem_addr[2] ? {32'h0, mem[mem_addr[6:3]][63:32]}
                                   : {32'h0, mem[mem_addr[6:3]][31:0]});

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req && mem_ready) begin
         accepts <= accepts + 1;
         if (mem_we) begin
            if (mem_size64) mem[mem_addr[6:3]] <= mem_wdata;
            else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
            else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
         end
      end
      if (done) done_seen <= done_seen + 1;
   end

   always @(negedge clk) begin
      if (mem_req && !mem_we) in_rmw <= 1'b1;
      if (in_rmw && !mem_lock && !done) lock_err <= lock_err + 1;
      if (done) in_rmw <= 1'b0;
   end

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int word_idx(input logic [15:0] d);
      logic [31:0] a;
      a = BASE + {{16{d[15]}}, d};
      return int'(a[6:3]);
   endfunction

   task automatic issue(input vec_t v);
      @(negedge clk);
      opcode = v.opc; sel = v.sel; disp = v.disp; src = v.src; r0 = v.r0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output logic ok);
      ok = 1'b0;
      for (int k = 0; k < 200; k++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input int n, input vec_t v);
      logic ok;
      int   idx;
      idx = word_idx(v.disp);
      for (int i = 0; i < 16; i++) mem[i] = 64'h0;
      mem[idx] = v.init;
      accepts = 0;
      issue(v);
      wait_done(ok);
      check(ok, "R11 done seen", 64'(ok), 64'h1);
      check(illegal == v.ill, v.ill ? "R1/R9 illegal flag" : "R1 legal op", 64'(illegal), 64'(v.ill));
      check(src_wb == v.swb, "R3 src write-back flag", 64'(src_wb), 64'(v.swb));
      if (v.swb) check(src_wb_data == v.sval, "R4/R8 src write-back value", src_wb_data, v.sval);
      check(r0_wb == v.rwb, "R6 r0 write-back flag", 64'(r0_wb), 64'(v.rwb));
      if (v.rwb) check(r0_wb_data == v.rval, "R6 r0 reload value", r0_wb_data, v.rval);
      if (v.ill) check(accepts == 0, "R9 no memory access", 64'(accepts), 64'h0);
      @(negedge clk);
      check(!done, "R11 done one cycle", 64'(done), 64'h0);
      check(mem[idx] == v.expw, "R2/R5/R7 memory word", mem[idx], v.expw);
      $display("vector %0d done", n);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 64'h0;
      repeat (3) @(negedge clk);
      check(!done && !mem_req && !mem_lock && !illegal, "R11 reset state",
            {60'h0, done, mem_req, mem_lock, illegal}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !mem_req && !mem_lock, "R10 idle after reset",
            {61'h0, done, mem_req, mem_lock}, 64'h0);

      for (int n = 0; n < NVEC; n++) run_vec(n, VEC[n]);

      // R10: stalled memory, lock must stay up across the whole window
      ready_delay = 3;
      run_vec(100, VEC[1]);
      run_vec(101, VEC[9]);
      check(lock_err == 0, "R10 lock held through RMW", 64'(lock_err), 64'h0);
      check(!mem_lock, "R10 lock released after done", 64'(mem_lock), 64'h0);

      // R11: start while busy is ignored
      begin
         vec_t a, b;
         logic ok;
         int   d0;
         a = VEC[0];
         b = VEC[4];
         b.disp = 16'h0000;
         for (int i = 0; i < 16; i++) mem[i] = 64'h0;
         mem[8] = 64'h5;
         d0 = done_seen;
         issue(a);
         @(negedge clk);
         opcode = b.opc; sel = b.sel; src = 64'h99; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done(ok);
         check(ok && !src_wb, "R11 first op completes", 64'(src_wb), 64'h0);
         repeat (12) @(negedge clk);
         check(done_seen - d0 == 1, "R11 busy start ignored (done count)", 64'(done_seen - d0), 64'h1);
         check(mem[8] == 64'h6, "R11 busy start ignored (memory)", mem[8], 64'h6);
      end
      ready_delay = 0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule